// File: doc/BRIEF.md
# Touch-Load Prefetch Line Buffer

This block keeps one prefetched cache line between a bus interface and a data cache. A touch request names an address. If that address is cacheable and copyback and prefetch is enabled, the block issues one line read to the bus. The returning beats are collected into a private line register, and none of them is written into the cache at that point. Each read carries a small fill identifier, and any beat whose identifier does not match the current fill is dropped. This lets a newer touch replace an older one while the older fill's beats are still arriving.

When the data cache misses on a load, it presents the load here. If the load is copyback and falls in the buffered line, the block raises a cancel in the same cycle so the cache does not start its own memory read. The whole line is then forwarded, and the buffer empties. If the matching load arrives while the fill is still running, the block holds the load and forwards the line right after the last beat lands. A write-through or caching-inhibited load that hits the line never takes the data. Instead it wipes the buffer, and so does a store to the line. A configuration bit, cleared at reset, turns every touch into a no-op that finishes in one cycle.

Top module: `prefetch_linebuf`

## Requirements
- R1: After reset the buffer is empty, `fwd_valid`, `ld_hold` and `ld_retry` are low, and the prefetch-disable bit is clear, so a load gets no cancel and a qualifying touch starts a read.
- R2: `touch_ack` is high in every cycle that `touch_valid` is high. A touch with `touch_cacheable`=1, `touch_wthru`=0 and prefetch enabled raises `bus_rd_req` in that same cycle. It places the line address (the touch address with its low 5 bits forced to zero) on `bus_rd_addr` and a fresh identifier on `bus_rd_id`.
- R3: A touch with `touch_cacheable`=0 or `touch_wthru`=1 raises no `bus_rd_req` and leaves a held line in place.
- R4: Writing 1 through `cfg_wr_en`/`cfg_touch_off` disables prefetch: touches raise no `bus_rd_req`. Writing 0 enables it again.
- R5: Beat k of a fill (k = 0..3, in arrival order) lands in `fwd_data[64k+63:64k]`. A beat whose `bus_beat_id` differs from the identifier of the running fill, or one that arrives when no fill is running, is ignored.
- R6: A copyback load (`ld_wthru`=0, `ld_inhibit`=0) whose address bits [31:5] equal the held line raises `cancel_rd` in the same cycle, at any offset in the line. `fwd_valid` is then high for exactly the next cycle with the full line, and the buffer is then empty.
- R7: A load to a different line gets no cancel and no forward, and the held line stays available.
- R8: A matching copyback load during a fill gets `cancel_rd`, and `ld_hold` is high from the next cycle. `fwd_valid` rises in the cycle after the last beat is taken, and `ld_hold` falls at the same time. Loads presented while `ld_hold` is high are ignored.
- R9: A write-through or caching-inhibited load never gets `cancel_rd`. If it matches the held or filling line, the buffer is invalidated and any running fill is abandoned.
- R10: A new qualifying touch replaces a pending or held line. The old line no longer hits, and beats still carrying the old identifier are ignored.
- R11: A store whose line matches invalidates the buffer. If a load is being held, `ld_retry` pulses in the next cycle, `ld_hold` falls, and no forward follows.
- R12: A touch presented while `ld_hold` is high raises no `bus_rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Loads the prefetch-disable bit |
| cfg_touch_off | input | 1 | Value written to the prefetch-disable bit |
| touch_valid | input | 1 | Touch request strobe |
| touch_addr | input | 32 | Touch byte address |
| touch_cacheable | input | 1 | Touch page is cacheable |
| touch_wthru | input | 1 | Touch page is write-through |
| touch_ack | output | 1 | Touch request finished this cycle |
| bus_rd_req | output | 1 | Start a line read on the bus |
| bus_rd_addr | output | 32 | Line-aligned read address |
| bus_rd_id | output | 2 | Identifier of the read being started |
| bus_beat_valid | input | 1 | Fill beat present |
| bus_beat_id | input | 2 | Identifier carried by the beat |
| bus_beat_data | input | 64 | Fill beat data |
| ld_valid | input | 1 | Data-cache load miss strobe |
| ld_addr | input | 32 | Load byte address |
| ld_wthru | input | 1 | Load page is write-through |
| ld_inhibit | input | 1 | Load page is caching-inhibited |
| cancel_rd | output | 1 | Suppress the memory read for this load |
| ld_hold | output | 1 | A claimed load waits for the fill |
| fwd_valid | output | 1 | Forwarded line present |
| fwd_data | output | 256 | Forwarded line |
| ld_retry | output | 1 | The held load lost its line and must go to memory |
| st_valid | input | 1 | Store strobe |
| st_addr | input | 32 | Store byte address |

## Verification
A wrong identifier or beat counter in the fill sequencer shows up as a forwarded line with beats swapped or stale. That error appears in the single cycle when `fwd_valid` is high, so every hit compares the whole 256-bit line against the pattern computed from the line address and the beat index. A stuck line-valid state shows up as `cancel_rd` on a load after invalidation, or as a missing cancel on a matching load, in the same cycle as the load. A lost hold flag shows up one cycle after the last beat, as a missing forward or a missing retry. The sweeps walk every touch attribute pair with prefetch on and off, every load attribute pair, and several line offsets.

// File: rtl/plb_pkg.sv
package plb_pkg;
   typedef enum logic [1:0] {
      BUF_EMPTY = 2'd0,
      BUF_FILL  = 2'd1,
      BUF_FULL  = 2'd2
   } buf_st_e;
endpackage

// File: rtl/plb_line_match.sv
// Line-granular address compare against the stored line tag.
module plb_line_match #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 5
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [ADDR_W-OFS_W-1:0] ref_tag,
   input  logic                    live,
   output logic                    hit
);
   localparam int TAG_W = ADDR_W - OFS_W;

   logic [TAG_W-1:0] req_tag;

   assign req_tag = addr[ADDR_W-1:OFS_W];
   assign hit     = live && (req_tag == ref_tag);
endmodule

// File: rtl/plb_fill_seq.sv
// Fill sequencing: state, line tag, fill identifier and beat counter.
module plb_fill_seq
   import plb_pkg::*;
#(
   parameter int TAG_W = 27,
   parameter int BEATS = 4,
   parameter int ID_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [TAG_W-1:0]         start_tag,
   input  logic                     abort,
   input  logic                     consume,
   input  logic                     beat_valid,
   input  logic [ID_W-1:0]          beat_id,
   output buf_st_e                  st,
   output logic [TAG_W-1:0]         tag,
   output logic [ID_W-1:0]          next_id,
   output logic                     beat_we,
   output logic [$clog2(BEATS)-1:0] beat_idx,
   output logic                     fill_done
);
   localparam int CNT_W = $clog2(BEATS);
   localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

   buf_st_e          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [TAG_W-1:0] tag_q;
   logic [ID_W-1:0]  id_q;
   logic             accept;
   logic             last;

   assign accept    = (st_q == BUF_FILL) && beat_valid && (beat_id == id_q);
   assign last      = (cnt_q == LAST_BEAT);
   assign fill_done = accept && last;
   assign beat_we   = accept;
   assign beat_idx  = cnt_q;
   assign next_id   = id_q + 1'b1;
   assign st        = st_q;
   assign tag       = tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= BUF_EMPTY;
         cnt_q <= '0;
         tag_q <= '0;
         id_q  <= '0;
      end else if (start) begin
         st_q  <= BUF_FILL;
         cnt_q <= '0;
         tag_q <= start_tag;
         id_q  <= next_id;
      end else if (abort || consume) begin
         st_q  <= BUF_EMPTY;
         cnt_q <= '0;
      end else if (accept) begin
         cnt_q <= cnt_q + 1'b1;
         if (last) begin
            st_q <= BUF_FULL;
         end
      end
   end
endmodule

// File: rtl/plb_line_store.sv
// Beat-addressed storage for one line.
module plb_line_store #(
   parameter int BEAT_W = 64,
   parameter int BEATS  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(BEATS)-1:0] idx,
   input  logic [BEAT_W-1:0]        wdata,
   output logic [BEAT_W*BEATS-1:0]  line
);
   localparam int CNT_W = $clog2(BEATS);

   for (genvar g = 0; g < BEATS; g++) begin : g_beat
      logic [BEAT_W-1:0] beat_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            beat_q <= '0;
         end else if (we && (idx == CNT_W'(g))) begin
            beat_q <= wdata;
         end
      end

      assign line[g*BEAT_W +: BEAT_W] = beat_q;
   end
endmodule

// File: rtl/prefetch_linebuf.sv
// Single floating line buffer fed by touch prefetches.
module prefetch_linebuf
   import plb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BEAT_W = 64,
   parameter int BEATS  = 4,
   parameter int ID_W   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr_en,
   input  logic                    cfg_touch_off,
   input  logic                    touch_valid,
   input  logic [ADDR_W-1:0]       touch_addr,
   input  logic                    touch_cacheable,
   input  logic                    touch_wthru,
   output logic                    touch_ack,
   output logic                    bus_rd_req,
   output logic [ADDR_W-1:0]       bus_rd_addr,
   output logic [ID_W-1:0]         bus_rd_id,
   input  logic                    bus_beat_valid,
   input  logic [ID_W-1:0]         bus_beat_id,
   input  logic [BEAT_W-1:0]       bus_beat_data,
   input  logic                    ld_valid,
   input  logic [ADDR_W-1:0]       ld_addr,
   input  logic                    ld_wthru,
   input  logic                    ld_inhibit,
   output logic                    cancel_rd,
   output logic                    ld_hold,
   output logic                    fwd_valid,
   output logic [BEAT_W*BEATS-1:0] fwd_data,
   output logic                    ld_retry,
   input  logic                    st_valid,
   input  logic [ADDR_W-1:0]       st_addr
);
   localparam int LINE_BYTES = (BEAT_W / 8) * BEATS;
   localparam int OFS_W      = $clog2(LINE_BYTES);
   localparam int TAG_W      = ADDR_W - OFS_W;
   localparam int CNT_W      = $clog2(BEATS);

   // Elaboration-time parameter checks
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("BEATS must be a power of two of at least 2");
   end
   if (BEAT_W < 8 || (BEAT_W % 8) != 0) begin : g_bad_beat_w
      $error("BEAT_W must be a whole number of bytes");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("ID_W must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the line size");
   end

   buf_st_e            buf_st;
   logic [TAG_W-1:0]   line_tag;
   logic [ID_W-1:0]    new_id;
   logic               beat_we;
   logic [CNT_W-1:0]   beat_idx;
   logic               fill_done;

   logic               touch_off_q;
   logic               wait_q;
   logic               fwd_q;
   logic               retry_q;

   logic               live;
   logic               filling;
   logic               full;
   logic               ld_tag_hit;
   logic               st_tag_hit;
   logic               ld_ok;
   logic               ld_take;
   logic               claim_now;
   logic               ld_kill;
   logic               st_kill;
   logic               fwd_now;
   logic               touch_go;
   logic               buf_abort;

   assign live    = (buf_st != BUF_EMPTY);
   assign filling = (buf_st == BUF_FILL);
   assign full    = (buf_st == BUF_FULL);

   plb_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ld_match (
      .addr    (ld_addr),
      .ref_tag (line_tag),
      .live    (live),
      .hit     (ld_tag_hit)
   );

   plb_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_st_match (
      .addr    (st_addr),
      .ref_tag (line_tag),
      .live    (live),
      .hit     (st_tag_hit)
   );

   // Load and store decisions
   assign ld_ok     = !ld_wthru && !ld_inhibit;
   assign ld_take   = ld_valid && !wait_q;
   assign st_kill   = st_valid && st_tag_hit;
   assign claim_now = ld_take && ld_ok && ld_tag_hit && !st_kill;
   assign ld_kill   = ld_take && !ld_ok && ld_tag_hit;
   assign buf_abort = st_kill || ld_kill;

   assign fwd_now = (claim_now && full) ||
                    ((wait_q || (claim_now && filling)) && fill_done && !st_kill);

   // Touch decisions
   assign touch_go = touch_valid && !touch_off_q && touch_cacheable &&
                     !touch_wthru && !wait_q && !claim_now;

   plb_fill_seq #(.TAG_W(TAG_W), .BEATS(BEATS), .ID_W(ID_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (touch_go),
      .start_tag  (touch_addr[ADDR_W-1:OFS_W]),
      .abort      (buf_abort),
      .consume    (fwd_now),
      .beat_valid (bus_beat_valid),
      .beat_id    (bus_beat_id),
      .st         (buf_st),
      .tag        (line_tag),
      .next_id    (new_id),
      .beat_we    (beat_we),
      .beat_idx   (beat_idx),
      .fill_done  (fill_done)
   );

   plb_line_store #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (beat_we),
      .idx   (beat_idx),
      .wdata (bus_beat_data),
      .line  (fwd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         touch_off_q <= 1'b0;
         wait_q      <= 1'b0;
         fwd_q       <= 1'b0;
         retry_q     <= 1'b0;
      end else begin
         if (cfg_wr_en) begin
            touch_off_q <= cfg_touch_off;
         end
         fwd_q   <= fwd_now;
         retry_q <= st_kill && wait_q;
         if (fwd_now || st_kill) begin
            wait_q <= 1'b0;
         end else if (claim_now && filling) begin
            wait_q <= 1'b1;
         end
      end
   end

   assign touch_ack   = touch_valid;
   assign bus_rd_req  = touch_go;
   assign bus_rd_addr = {touch_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
   assign bus_rd_id   = new_id;
   assign cancel_rd   = claim_now;
   assign ld_hold     = wait_q;
   assign fwd_valid   = fwd_q;
   assign ld_retry    = retry_q;
endmodule

// File: rtl/prefetch_linebuf_chk.sv
// Property checker attached to prefetch_linebuf.
module prefetch_linebuf_chk #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              touch_valid,
   input logic              touch_cacheable,
   input logic              touch_wthru,
   input logic              touch_ack,
   input logic              touch_off_q,
   input logic              bus_rd_req,
   input logic [ADDR_W-1:0] bus_rd_addr,
   input logic              ld_valid,
   input logic              ld_wthru,
   input logic              ld_inhibit,
   input logic              cancel_rd,
   input logic              ld_hold,
   input logic              fwd_valid,
   input logic              ld_retry
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!fwd_valid && !ld_hold && !ld_retry));

   p_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      touch_valid |-> touch_ack);

   p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_req |-> (bus_rd_addr[OFS_W-1:0] == '0));

   p_noop_attr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_valid && (!touch_cacheable || touch_wthru)) |-> !bus_rd_req);

   p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      touch_off_q |-> !bus_rd_req);

   p_fwd_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> ($past(cancel_rd) || $past(ld_hold)));

   p_hold_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hold |-> !cancel_rd);

   p_uncached_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && (ld_wthru || ld_inhibit)) |-> !cancel_rd);

   p_retry_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_retry |-> ($past(ld_hold) && !ld_hold && !fwd_valid));

   p_hold_touch_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hold |-> !bus_rd_req);
endmodule

bind prefetch_linebuf prefetch_linebuf_chk #(
   .ADDR_W (ADDR_W),
   .OFS_W  (OFS_W)
) u_chk (.*);

// File: tb/prefetch_linebuf_tb.sv
module prefetch_linebuf_tb;
   localparam int ADDR_W = 32;
   localparam int BEAT_W = 64;
   localparam int BEATS  = 4;
   localparam int ID_W   = 2;
   localparam int LINE_W = BEAT_W * BEATS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr_en = 1'b0;
   logic              cfg_touch_off = 1'b0;
   logic              touch_valid = 1'b0;
   logic [ADDR_W-1:0] touch_addr = '0;
   logic              touch_cacheable = 1'b0;
   logic              touch_wthru = 1'b0;
   logic              touch_ack;
   logic              bus_rd_req;
   logic [ADDR_W-1:0] bus_rd_addr;
   logic [ID_W-1:0]   bus_rd_id;
   logic              bus_beat_valid = 1'b0;
   logic [ID_W-1:0]   bus_beat_id = '0;
   logic [BEAT_W-1:0] bus_beat_data = '0;
   logic              ld_valid = 1'b0;
   logic [ADDR_W-1:0] ld_addr = '0;
   logic              ld_wthru = 1'b0;
   logic              ld_inhibit = 1'b0;
   logic              cancel_rd;
   logic              ld_hold;
   logic              fwd_valid;
   logic [LINE_W-1:0] fwd_data;
   logic              ld_retry;
   logic              st_valid = 1'b0;
   logic [ADDR_W-1:0] st_addr = '0;

   int          n_chk  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;
   logic [ID_W-1:0] last_id = '0;

   always #10 clk = ~clk;

   prefetch_linebuf #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BEATS(BEATS), .ID_W(ID_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_touch_off(cfg_touch_off),
      .touch_valid(touch_valid), .touch_addr(touch_addr),
      .touch_cacheable(touch_cacheable), .touch_wthru(touch_wthru), .touch_ack(touch_ack),
      .bus_rd_req(bus_rd_req), .bus_rd_addr(bus_rd_addr), .bus_rd_id(bus_rd_id),
      .bus_beat_valid(bus_beat_valid), .bus_beat_id(bus_beat_id), .bus_beat_data(bus_beat_data),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_wthru(ld_wthru), .ld_inhibit(ld_inhibit),
      .cancel_rd(cancel_rd), .ld_hold(ld_hold),
      .fwd_valid(fwd_valid), .fwd_data(fwd_data), .ld_retry(ld_retry),
      .st_valid(st_valid), .st_addr(st_addr)
   );

   function automatic logic [BEAT_W-1:0] beat_of(input logic [ADDR_W-1:0] la, input int k);
      return {la, 32'h5A00_0000 + 32'(k * 17)};
   endfunction

   function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] la);
      logic [LINE_W-1:0] v;
      for (int k = 0; k < BEATS; k++) v[k*BEAT_W +: BEAT_W] = beat_of(la, k);
      return v;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_cfg(input logic off);
      cfg_wr_en = 1'b1; cfg_touch_off = off;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic do_touch(input logic [ADDR_W-1:0] a, input logic c, input logic wt,
                           input logic exp_req, input string req);
      touch_valid = 1'b1; touch_addr = a; touch_cacheable = c; touch_wthru = wt;
      #1;
      chk(touch_ack == 1'b1, "R2 ack", LINE_W'(touch_ack), 1);
      chk(bus_rd_req == exp_req, req, LINE_W'(bus_rd_req), LINE_W'(exp_req));
      if (exp_req) begin
         chk(bus_rd_addr == {a[31:5], 5'b0}, "R2 addr", LINE_W'(bus_rd_addr),
             LINE_W'({a[31:5], 5'b0}));
         last_id = bus_rd_id;
      end
      @(negedge clk);
      touch_valid = 1'b0;
   endtask

   task automatic do_beat(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] la, input int k);
      bus_beat_valid = 1'b1; bus_beat_id = id; bus_beat_data = beat_of(la, k);
      @(negedge clk);
      bus_beat_valid = 1'b0;
   endtask

   task automatic do_fill(input logic [ADDR_W-1:0] la);
      for (int k = 0; k < BEATS; k++) do_beat(last_id, la, k);
   endtask

   task automatic do_load(input logic [ADDR_W-1:0] a, input logic wt, input logic ci,
                          input logic exp_cancel, input logic exp_fwd,
                          input logic [ADDR_W-1:0] la, input string req);
      ld_valid = 1'b1; ld_addr = a; ld_wthru = wt; ld_inhibit = ci;
      #1;
      chk(cancel_rd == exp_cancel, req, LINE_W'(cancel_rd), LINE_W'(exp_cancel));
      @(negedge clk);
      ld_valid = 1'b0; ld_wthru = 1'b0; ld_inhibit = 1'b0;
      chk(fwd_valid == exp_fwd, req, LINE_W'(fwd_valid), LINE_W'(exp_fwd));
      if (exp_fwd) chk(fwd_data == line_of(la), req, fwd_data, line_of(la));
   endtask

   task automatic do_store(input logic [ADDR_W-1:0] a);
      st_valid = 1'b1; st_addr = a;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] la, lb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(!fwd_valid && !ld_hold && !ld_retry && !bus_rd_req, "R1 reset outputs",
          LINE_W'({fwd_valid, ld_hold, ld_retry, bus_rd_req}), 0);
      do_load(32'h0000_0040, 0, 0, 0, 0, 0, "R1 empty load");

      // R2/R3/R4: sweep touch attributes with prefetch on and off
      for (int off = 0; off < 2; off++) begin
         do_cfg(off[0]);
         for (int c = 0; c < 2; c++) begin
            for (int wt = 0; wt < 2; wt++) begin
               la = 32'h2000_0000 + 32'((off * 4 + c * 2 + wt) * 64);
               if (off == 0 && c == 1 && wt == 0) begin
                  do_touch(la + 32'h1F, 1, 0, 1, "R2 touch starts read");
                  do_fill(la);
                  do_load(la + 32'h08, 0, 0, 1, 1, la, "R6 hit after sweep touch");
               end else begin
                  do_touch(la, c[0], wt[0], 0,
                           (off == 1) ? "R4 disabled touch" : "R3 no-op attribute touch");
                  do_load(la, 0, 0, 0, 0, 0, "R3 no line after no-op touch");
               end
            end
         end
      end
      do_cfg(1'b0);
      do_touch(32'h2100_0000, 1, 0, 1, "R4 re-enabled touch");
      do_fill(32'h2100_0000);
      do_load(32'h2100_0000, 0, 0, 1, 1, 32'h2100_0000, "R4 re-enabled hit");

      // R3: no-op touch leaves held line
      la = 32'h2200_0000;
      do_touch(la, 1, 0, 1, "R2 touch");
      do_fill(la);
      do_touch(32'h2300_0000, 0, 0, 0, "R3 inhibited touch while held");
      do_touch(32'h2300_0000, 1, 1, 0, "R3 write-through touch while held");
      do_load(la + 32'h10, 0, 0, 1, 1, la, "R3 held line kept");

      // R6: offset sweep and single use
      for (int o = 0; o < 32; o += 7) begin
         la = 32'h3000_0000 + 32'(o * 32);
         do_touch(la, 1, 0, 1, "R2 touch");
         do_fill(la);
         do_load(la + 32'(o), 0, 0, 1, 1, la, "R6 hit at offset");
         do_load(la + 32'(o), 0, 0, 0, 0, 0, "R6 buffer empty after forward");
      end

      // R7: other line misses, line kept
      la = 32'h3100_0000;
      do_touch(la, 1, 0, 1, "R2 touch");
      do_fill(la);
      do_load(la + 32'h20, 0, 0, 0, 0, 0, "R7 neighbour line misses");
      do_load(la - 32'h01, 0, 0, 0, 0, 0, "R7 previous line misses");
      do_load(la + 32'h18, 0, 0, 1, 1, la, "R7 line still held");

      // R5: stray beats ignored
      do_beat(last_id, 32'hDEAD_0000, 0);
      la = 32'h3200_0000;
      do_touch(la, 1, 0, 1, "R2 touch");
      do_beat(last_id + 1'b1, 32'hBAD0_0000, 0);
      do_beat(last_id - 1'b1, 32'hBAD1_0000, 0);
      do_fill(la);
      do_load(la, 0, 0, 1, 1, la, "R5 beats ordered, strays dropped");

      // R8/R12: load during fill is held then forwarded
      la = 32'h4000_0000;
      do_touch(la, 1, 0, 1, "R2 touch");
      do_beat(last_id, la, 0);
      do_beat(last_id, la, 1);
      do_load(la + 32'h04, 0, 0, 1, 0, 0, "R8 claim during fill");
      chk(ld_hold == 1'b1, "R8 hold raised", LINE_W'(ld_hold), 1);
      do_load(la + 32'h04, 0, 0, 0, 0, 0, "R8 load ignored while held");
      do_touch(32'h4100_0000, 1, 0, 0, "R12 touch during hold");
      do_beat(last_id, la, 2);
      chk(fwd_valid == 1'b0, "R8 no forward before last beat", LINE_W'(fwd_valid), 0);
      do_beat(last_id, la, 3);
      chk(fwd_valid == 1'b1, "R8 forward after last beat", LINE_W'(fwd_valid), 1);
      chk(fwd_data == line_of(la), "R8 forwarded line", fwd_data, line_of(la));
      chk(ld_hold == 1'b0, "R8 hold released", LINE_W'(ld_hold), 0);
      @(negedge clk);
      chk(fwd_valid == 1'b0, "R6 forward one cycle", LINE_W'(fwd_valid), 0);

      // R9: uncached or write-through matching loads invalidate
      for (int a = 1; a < 4; a++) begin
         la = 32'h5000_0000 + 32'(a * 32);
         do_touch(la, 1, 0, 1, "R2 touch");
         do_fill(la);
         do_load(la + 32'h08, a[0], a[1], 0, 0, 0, "R9 uncached load no cancel");
         do_load(la, 0, 0, 0, 0, 0, "R9 buffer invalidated");
      end
      la = 32'h5100_0000;
      do_touch(la, 1, 0, 1, "R2 touch");
      do_beat(last_id, la, 0);
      do_load(la, 0, 1, 0, 0, 0, "R9 inhibited load during fill");
      for (int k = 1; k < BEATS; k++) do_beat(last_id, la, k);
      do_load(la, 0, 0, 0, 0, 0, "R9 fill abandoned");

      // R10: replacement
      la = 32'h6000_0000; lb = 32'h6000_1000;
      do_touch(la, 1, 0, 1, "R2 touch");
      begin
         logic [ID_W-1:0] old_id;
         old_id = last_id;
         do_beat(old_id, la, 0);
         do_touch(lb, 1, 0, 1, "R10 replacing touch");
         chk(last_id != old_id, "R10 fresh id", LINE_W'(last_id), LINE_W'(old_id + 1'b1));
         for (int k = 1; k < BEATS; k++) do_beat(old_id, la, k);
      end
      do_fill(lb);
      do_load(la, 0, 0, 0, 0, 0, "R10 old line gone");
      do_load(lb + 32'h1C, 0, 0, 1, 1, lb, "R10 new line hits");

      // R11: stores
      la = 32'h7000_0000;
      do_touch(la, 1, 0, 1, "R2 touch");
      do_fill(la);
      do_store(la + 32'h40);
      do_load(la, 0, 0, 1, 1, la, "R11 other-line store keeps line");
      do_touch(la, 1, 0, 1, "R2 touch");
      do_fill(la);
      do_store(la + 32'h0C);
      do_load(la, 0, 0, 0, 0, 0, "R11 matching store invalidates");
      do_touch(la, 1, 0, 1, "R2 touch");
      do_beat(last_id, la, 0);
      do_load(la, 0, 0, 1, 0, 0, "R8 claim during fill");
      do_store(la + 32'h10);
      chk(ld_retry == 1'b1, "R11 retry pulse", LINE_W'(ld_retry), 1);
      chk(ld_hold == 1'b0, "R11 hold dropped", LINE_W'(ld_hold), 0);
      for (int k = 1; k < BEATS; k++) begin
         do_beat(last_id, la, k);
         chk(fwd_valid == 1'b0 && ld_retry == 1'b0, "R11 no forward after kill",
             LINE_W'({fwd_valid, ld_retry}), 0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule